// File: doc/BRIEF.md
# Programmable Output Logic Cell

This block is one output cell of a small programmable logic device. A group of product terms from the AND plane arrives on a vector. The cell ORs them into one sum and passes the sum through an XOR with a per-cell polarity bit. The result then goes to the pin in one of two ways. It can go straight to the pin, or it can go through a D flip-flop clocked by the device clock. The pin is modelled as three separate signals: a driven value, a drive enable and the sampled pin level.

Two mode bits set how the cell behaves. One is a global mode bit shared by the device and the other belongs to this cell. Together they choose one of four modes: simple combinational output, dedicated input, registered output, or combinational output with a selectable enable. The cell also returns one signal to the AND plane as feedback. Depending on the mode, that signal is the register, the pin level, or the output of the neighbouring cell. In simple output mode, the neighbour's own cell mode bit decides whether the neighbour's output is used.

Top module: `olmc_cell`

## Requirements
- R1: In every mode other than registered, `pin_out` equals the OR of all `pterm` bits XOR `pol`.
- R2: Registered mode is global bit 1 and cell bit 0. In this mode `pin_out` equals the OR-XOR sum captured at the previous rising clock edge.
- R3: When `rst` is high at a rising edge, the register clears to 0. `rst` has priority over capture, so registered `pin_out` reads 0 after that edge.
- R4: In registered mode, `pin_oe` follows `oe_pin`.
- R5: Enable-select mode is global bit 1 and cell bit 1. In this mode `pin_oe` is set by `oe_sel`: code 11 gives 1, 10 gives `oe_pin`, 01 gives `pterm_oe`, and 00 gives 0.
- R6: Simple output mode is global bit 0 and cell bit 0. In this mode `pin_oe` is 1.
- R7: Dedicated input mode is global bit 0 and cell bit 1. In this mode `pin_oe` is 0 and `fb` equals `pin_in`.
- R8: In registered mode, `fb` equals the register value.
- R9: In enable-select mode, `fb` equals `pin_in`.
- R10: In simple output mode, `fb` equals `nbr_out` when `nbr_mode` is 1 and 0 when `nbr_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous reset of the register, active high |
| pterm | input | N_TERMS | Product terms from the AND plane |
| pterm_oe | input | 1 | Product term used as an output enable |
| pol | input | 1 | Output polarity bit |
| glb_mode | input | 1 | Global mode bit |
| cell_mode | input | 1 | Mode bit of this cell |
| nbr_mode | input | 1 | Mode bit of the adjacent cell |
| oe_sel | input | 2 | Enable source select |
| oe_pin | input | 1 | Device output-enable pin |
| nbr_out | input | 1 | Output of the adjacent cell |
| pin_in | input | 1 | Sampled pin level |
| pin_out | output | 1 | Value driven to the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback to the AND plane |

## Verification
The bench builds the cell with `N_TERMS` = 4. At that width every combination of the terms, the polarity, the three mode bits, the enable select and the four single-bit sources fits in 16384 clock cycles. That sweep reaches every mode against every enable code and every feedback source. It also checks the register against a value the bench carries forward on its own from cycle to cycle. Separate reset sequences show that a reset at a clock edge takes priority over a set sum.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

  typedef enum logic [1:0] {
    MODE_SIMPLE = 2'b00,
    MODE_INPUT  = 2'b01,
    MODE_REG    = 2'b10,
    MODE_OESEL  = 2'b11
  } cell_mode_e;

  function automatic cell_mode_e decode_mode(input logic glb, input logic own);
    return cell_mode_e'({glb, own});
  endfunction

  function automatic logic oe_pick(input logic [1:0] sel, input logic dev_oe, input logic pt_oe);
    case (sel)
      2'b11:   return 1'b1;
      2'b10:   return dev_oe;
      2'b01:   return pt_oe;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/olmc_sum.sv
module olmc_sum #(
  parameter int N_TERMS = 8
) (
  input  logic [N_TERMS-1:0] pterm,
  input  logic               pol,
  output logic               sum_bit
);
  logic [N_TERMS:0] chain;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N_TERMS; i++) begin : g_or
    assign chain[i+1] = chain[i] | pterm[i];
  end

  assign sum_bit = chain[N_TERMS] ^ pol;
endmodule

// File: rtl/olmc_oe_mux.sv
module olmc_oe_mux
  import olmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cell_mode_e mode,
  input  logic [1:0] oe_sel,
  input  logic       oe_pin,
  input  logic       pterm_oe,
  output logic       oe
);
  always_comb begin
    case (mode)
      MODE_SIMPLE: oe = 1'b1;
      MODE_INPUT:  oe = 1'b0;
      MODE_REG:    oe = oe_pin;
      default:     oe = oe_pick(oe_sel, oe_pin, pterm_oe);
    endcase
  end

  p_oe_code_low_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OESEL && oe_sel == 2'b00) |-> !oe);
  p_oe_code_high_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OESEL && oe_sel == 2'b11) |-> oe);
  p_simple_on_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SIMPLE) |-> oe);
endmodule

// File: rtl/olmc_fb_mux.sv
module olmc_fb_mux
  import olmc_pkg::*;
(
  input  cell_mode_e mode,
  input  logic       nbr_mode,
  input  logic       q,
  input  logic       pin_in,
  input  logic       nbr_out,
  output logic       fb
);
  always_comb begin
    case (mode)
      MODE_REG:    fb = q;
      MODE_SIMPLE: fb = nbr_mode ? nbr_out : 1'b0;
      default:     fb = pin_in;
    endcase
  end
endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
  import olmc_pkg::*;
#(
  parameter int N_TERMS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_TERMS-1:0] pterm,
  input  logic               pterm_oe,
  input  logic               pol,
  input  logic               glb_mode,
  input  logic               cell_mode,
  input  logic               nbr_mode,
  input  logic [1:0]         oe_sel,
  input  logic               oe_pin,
  input  logic               nbr_out,
  input  logic               pin_in,
  output logic               pin_out,
  output logic               pin_oe,
  output logic               fb
);
  cell_mode_e mode;
  logic       sum_bit;
  logic       q_reg;
  logic       reg_mode;

  assign mode     = decode_mode(glb_mode, cell_mode);
  assign reg_mode = (mode == MODE_REG);

  olmc_sum #(.N_TERMS(N_TERMS)) u_sum (
    .pterm   (pterm),
    .pol     (pol),
    .sum_bit (sum_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) q_reg <= 1'b0;
    else     q_reg <= sum_bit;
  end

  olmc_oe_mux u_oe (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .oe_sel   (oe_sel),
    .oe_pin   (oe_pin),
    .pterm_oe (pterm_oe),
    .oe       (pin_oe)
  );

  olmc_fb_mux u_fb (
    .mode    (mode),
    .nbr_mode(nbr_mode),
    .q       (q_reg),
    .pin_in  (pin_in),
    .nbr_out (nbr_out),
    .fb      (fb)
  );

  assign pin_out = reg_mode ? q_reg : sum_bit;

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (q_reg == $past(sum_bit)));
  p_reset_clear_r3: assert property (@(posedge clk)
    rst |=> (q_reg == 1'b0));
  p_reg_oe_r4: assert property (@(posedge clk) disable iff (rst)
    reg_mode |-> (pin_oe == oe_pin));
  p_input_off_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_INPUT) |-> (!pin_oe && fb == pin_in));
  p_reg_fb_r8: assert property (@(posedge clk) disable iff (rst)
    reg_mode |-> (fb == pin_out));
endmodule

// File: tb/sim_olmc_cell.sv
module sim_olmc_cell;
  localparam int NT = 4;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NT-1:0] pterm = '0;
  logic pterm_oe = 0, pol = 0, glb_mode = 0, cell_mode = 0, nbr_mode = 0;
  logic [1:0] oe_sel = 2'b00;
  logic oe_pin = 0, nbr_out = 0, pin_in = 0;
  logic pin_out, pin_oe, fb;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic model_q = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  olmc_cell #(.N_TERMS(NT)) u0 (
    .clk(clk), .rst(rst), .pterm(pterm), .pterm_oe(pterm_oe), .pol(pol),
    .glb_mode(glb_mode), .cell_mode(cell_mode), .nbr_mode(nbr_mode),
    .oe_sel(oe_sel), .oe_pin(oe_pin), .nbr_out(nbr_out), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_sum(input logic [NT-1:0] t, input logic p);
    return (t != 0) ^ p;
  endfunction

  initial begin
    // R3: reset clears the register even with the sum high
    glb_mode = 1; cell_mode = 0; pterm = '1; pol = 0; oe_pin = 1;
    rst = 1;
    @(posedge clk); @(negedge clk);
    check("R3 reset state", pin_out, 1'b0);
    check("R4 reset state oe", pin_oe, 1'b1);
    rst = 0;
    @(posedge clk); @(negedge clk);
    check("R2 first capture", pin_out, 1'b1);
    model_q = 1'b1;

    for (int c = 0; c < 16384; c++) begin
      @(negedge clk);
      pterm     = c[3:0];
      pol       = c[4];
      glb_mode  = c[5];
      cell_mode = c[6];
      nbr_mode  = c[7];
      oe_sel    = c[9:8];
      oe_pin    = c[10];
      pterm_oe  = c[11];
      nbr_out   = c[12];
      pin_in    = c[13];
      #1;
      case ({glb_mode, cell_mode})
        2'b10: begin
          check("R2 registered out", pin_out, model_q);
          check("R4 registered oe", pin_oe, oe_pin);
          check("R8 registered fb", fb, model_q);
        end
        2'b11: begin
          check("R1 comb out", pin_out, exp_sum(pterm, pol));
          check("R5 oe select", pin_oe,
                oe_sel == 2'b11 ? 1'b1 : oe_sel == 2'b10 ? oe_pin :
                oe_sel == 2'b01 ? pterm_oe : 1'b0);
          check("R9 pin fb", fb, pin_in);
        end
        2'b00: begin
          check("R1 simple out", pin_out, exp_sum(pterm, pol));
          check("R6 simple oe", pin_oe, 1'b1);
          check("R10 neighbour fb", fb, nbr_mode ? nbr_out : 1'b0);
        end
        default: begin
          check("R1 input-mode out", pin_out, exp_sum(pterm, pol));
          check("R7 input oe", pin_oe, 1'b0);
          check("R7 input fb", fb, pin_in);
        end
      endcase
      @(posedge clk);
      model_q = exp_sum(pterm, pol);
    end

    // R3: reset mid-run after a captured 1
    @(negedge clk);
    glb_mode = 1; cell_mode = 0; pterm = 4'b0100; pol = 0; oe_pin = 0;
    @(posedge clk); @(negedge clk);
    check("R2 capture before reset", pin_out, 1'b1);
    check("R4 oe low", pin_oe, 1'b0);
    rst = 1;
    @(posedge clk); @(negedge clk);
    check("R3 reset priority", pin_out, 1'b0);
    check("R8 fb after reset", fb, 1'b0);
    rst = 0; pol = 1;
    @(posedge clk); @(negedge clk);
    check("R2 inverted capture", pin_out, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule